// File: doc/BRIEF.md
# Image sensor frame timing generator

This block drives the framing signals of a progressive-scan image sensor output port. Every clock it emits a frame-valid flag, a line-valid flag and a 10-bit pixel word. Each frame has this order. First comes a quiet vertical gap with both flags low. Frame-valid then rises, and a short head gap passes before the first line. The active lines follow, one after another, with a horizontal gap between each pair of lines. A short tail gap comes after the last line, and then frame-valid falls again. The pixel words come from a built-in ramp pattern, so a downstream receiver can be checked for pixel order without a real imager.

All interval lengths are parameters. The defaults describe a wide-VGA frame: 752 pixels by 480 lines, a horizontal gap of 94 clocks, a head gap of 71 clocks, a tail gap of 23 clocks and a vertical gap of 38,074 clocks. A full frame then takes 444,154 clocks. The enable input lets a running frame finish before output stops. The synchronous reset puts the block back at the start of the vertical gap.

Top module: `sensor_frame_timer`

## Requirements
- R1: While `srst` is high, and on the first cycle after it, `frame_valid`, `line_valid` and `pix_data` are all zero. The block then restarts at the first cycle of the vertical gap.
- R2: `line_valid` stays high for exactly ACTIVE_PIX consecutive cycles per line, and a frame contains exactly ACTIVE_ROWS lines.
- R3: Consecutive lines are separated by exactly ROW_GAP cycles with `frame_valid` high and `line_valid` low. No such gap follows the last line.
- R4: After `frame_valid` rises, exactly HEAD_GAP cycles pass with `line_valid` low before the first line starts.
- R5: After the last line ends, `frame_valid` stays high for exactly TAIL_GAP cycles and then falls.
- R6: With `enable` held high, `frame_valid` stays low for exactly FRAME_GAP cycles between frames. It is high for HEAD_GAP + ACTIVE_ROWS*ACTIVE_PIX + (ACTIVE_ROWS-1)*ROW_GAP + TAIL_GAP cycles per frame.
- R7: During an active pixel, `pix_data` equals (row + column) mod 1024. The row counts from 0 at the first line of the frame, and the column counts from 0 at the first pixel of the line.
- R8: `pix_data` is zero in every cycle where `line_valid` is low.
- R9: `line_valid` is never high while `frame_valid` is low.
- R10: If `enable` goes low during a frame, that frame completes, and all outputs then stay low for as long as `enable` stays low. If `enable` goes high again after the vertical gap has elapsed, `frame_valid` rises on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all outputs change on its rising edge |
| srst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows a new frame to start once the vertical gap has elapsed |
| frame_valid | output | 1 | High across the head gap, the lines and the tail gap of a frame |
| line_valid | output | 1 | High while a pixel word is valid |
| pix_data | output | 10 | Test-pattern pixel word, zero outside active pixels |

## Verification
The three outputs come from flops that load the next phase of the sequencer, so every output belongs to the cycle that follows the edge at which the counters move. An output never lags a phase change by an extra register. After reset is released, the first sample seen on the falling edge is cycle 0 of the vertical gap. The expected stream therefore begins one cycle into the gap, and each later falling-edge sample takes exactly one queued item. When `enable` is raised after the gap has run out, the next sampled cycle must already show the head gap. A reset in the middle of a frame drops the queued expectations and starts a fresh stream at the same offset.

// File: rtl/sft_pkg.sv
package sft_pkg;

  localparam int PIX_W = 10;

  typedef enum logic [2:0] {
    PH_VGAP   = 3'd0,
    PH_HEAD   = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_HGAP   = 3'd3,
    PH_TAIL   = 3'd4
  } phase_t;

  // Largest of the interval lengths, used to size the span counter.
  function automatic int span_max(input int a, input int b, input int c,
                                  input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  // Test pattern word: (row + column) modulo 2**PIX_W.
  function automatic logic [PIX_W-1:0] ramp_word(input int unsigned row,
                                                 input int unsigned col);
    int unsigned s;
    s = row + col;
    return s[PIX_W-1:0];
  endfunction

  // Clocks during which frame_valid is high.
  function automatic int frame_high_len(input int px, input int rows,
                                        input int hgap, input int head,
                                        input int tail);
    return head + rows * px + (rows - 1) * hgap + tail;
  endfunction

endpackage

// File: rtl/sft_phase_seq.sv
module sft_phase_seq
  import sft_pkg::*;
#(
  parameter int ACTIVE_PIX  = 752,
  parameter int ACTIVE_ROWS = 480,
  parameter int ROW_GAP     = 94,
  parameter int HEAD_GAP    = 71,
  parameter int TAIL_GAP    = 23,
  parameter int FRAME_GAP   = 38074,
  parameter int CNT_W       = 16,
  parameter int ROW_W       = 9
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             enable,
  output phase_t           phase_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [ROW_W-1:0] row_q,
  output phase_t           phase_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic [ROW_W-1:0] row_d,
  output logic             span_done,
  output logic             last_row
);

  localparam logic [CNT_W-1:0] VGAP_LAST = CNT_W'(FRAME_GAP - 1);
  localparam logic [CNT_W-1:0] HEAD_LAST = CNT_W'(HEAD_GAP - 1);
  localparam logic [CNT_W-1:0] PIX_LAST  = CNT_W'(ACTIVE_PIX - 1);
  localparam logic [CNT_W-1:0] HGAP_LAST = CNT_W'(ROW_GAP - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_GAP - 1);
  localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(ACTIVE_ROWS - 1);

  logic [CNT_W-1:0] span_last;

  always_comb begin
    unique case (phase_q)
      PH_HEAD:   span_last = HEAD_LAST;
      PH_ACTIVE: span_last = PIX_LAST;
      PH_HGAP:   span_last = HGAP_LAST;
      PH_TAIL:   span_last = TAIL_LAST;
      default:   span_last = VGAP_LAST;
    endcase
  end

  assign span_done = (cnt_q == span_last);
  assign last_row  = (row_q == ROW_LAST);

  always_comb begin
    phase_d = phase_q;
    row_d   = row_q;
    cnt_d   = cnt_q + CNT_W'(1);
    if (span_done) begin
      cnt_d = '0;
      unique case (phase_q)
        PH_VGAP: begin
          if (enable) begin
            phase_d = PH_HEAD;
          end else begin
            cnt_d = cnt_q;           // gap elapsed: wait here for enable
          end
        end
        PH_HEAD: begin
          phase_d = PH_ACTIVE;
          row_d   = '0;
        end
        PH_ACTIVE: phase_d = last_row ? PH_TAIL : PH_HGAP;
        PH_HGAP: begin
          phase_d = PH_ACTIVE;
          row_d   = row_q + ROW_W'(1);
        end
        PH_TAIL: phase_d = PH_VGAP;
        default: phase_d = PH_VGAP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      phase_q <= PH_VGAP;
      cnt_q   <= '0;
      row_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      row_q   <= row_d;
    end
  end

endmodule

// File: rtl/sft_ramp_pattern.sv
module sft_ramp_pattern
  import sft_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ROW_W = 9
) (
  input  logic             active,
  input  logic [ROW_W-1:0] row,
  input  logic [CNT_W-1:0] col,
  output logic [PIX_W-1:0] word
);

  always_comb begin
    if (active) word = ramp_word(32'(row), 32'(col));
    else        word = '0;
  end

endmodule

// File: rtl/sft_out_stage.sv
module sft_out_stage
  import sft_pkg::*;
(
  input  logic             clk,
  input  logic             srst,
  input  phase_t           phase_d,
  input  logic [PIX_W-1:0] word_d,
  output logic             fv_q,
  output logic             lv_q,
  output logic [PIX_W-1:0] pix_q
);

  always_ff @(posedge clk) begin
    if (srst) begin
      fv_q  <= 1'b0;
      lv_q  <= 1'b0;
      pix_q <= '0;
    end else begin
      fv_q  <= (phase_d != PH_VGAP);
      lv_q  <= (phase_d == PH_ACTIVE);
      pix_q <= word_d;
    end
  end

endmodule

// File: rtl/sensor_frame_timer.sv
module sensor_frame_timer
  import sft_pkg::*;
#(
  parameter int ACTIVE_PIX  = 752,
  parameter int ACTIVE_ROWS = 480,
  parameter int ROW_GAP     = 94,
  parameter int HEAD_GAP    = 71,
  parameter int TAIL_GAP    = 23,
  parameter int FRAME_GAP   = 38074
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             enable,
  output logic             frame_valid,
  output logic             line_valid,
  output logic [PIX_W-1:0] pix_data
);

  localparam int MAX_SPAN = span_max(ACTIVE_PIX, ROW_GAP, HEAD_GAP,
                                     TAIL_GAP, FRAME_GAP);
  localparam int CNT_W    = $clog2(MAX_SPAN + 1);
  localparam int ROW_W    = $clog2(ACTIVE_ROWS) + 1;

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             span_done;
  logic             last_row;
  logic             next_active;
  logic [PIX_W-1:0] word_d;

  sft_phase_seq #(
    .ACTIVE_PIX (ACTIVE_PIX),
    .ACTIVE_ROWS(ACTIVE_ROWS),
    .ROW_GAP    (ROW_GAP),
    .HEAD_GAP   (HEAD_GAP),
    .TAIL_GAP   (TAIL_GAP),
    .FRAME_GAP  (FRAME_GAP),
    .CNT_W      (CNT_W),
    .ROW_W      (ROW_W)
  ) u_seq (
    .clk      (clk),
    .srst     (srst),
    .enable   (enable),
    .phase_q  (phase_q),
    .cnt_q    (cnt_q),
    .row_q    (row_q),
    .phase_d  (phase_d),
    .cnt_d    (cnt_d),
    .row_d    (row_d),
    .span_done(span_done),
    .last_row (last_row)
  );

  assign next_active = (phase_d == PH_ACTIVE);

  sft_ramp_pattern #(
    .CNT_W(CNT_W),
    .ROW_W(ROW_W)
  ) u_ramp (
    .active(next_active),
    .row   (row_d),
    .col   (cnt_d),
    .word  (word_d)
  );

  sft_out_stage u_out (
    .clk    (clk),
    .srst   (srst),
    .phase_d(phase_d),
    .word_d (word_d),
    .fv_q   (frame_valid),
    .lv_q   (line_valid),
    .pix_q  (pix_data)
  );

endmodule

// File: rtl/sensor_frame_timer_chk.sv
module sensor_frame_timer_chk
  import sft_pkg::*;
#(
  parameter int ACTIVE_PIX  = 752,
  parameter int ACTIVE_ROWS = 480,
  parameter int ROW_GAP     = 94,
  parameter int HEAD_GAP    = 71,
  parameter int TAIL_GAP    = 23
) (
  input logic             clk,
  input logic             srst,
  input logic             frame_valid,
  input logic             line_valid,
  input logic [PIX_W-1:0] pix_data
);

  localparam int FV_LEN = frame_high_len(ACTIVE_PIX, ACTIVE_ROWS, ROW_GAP,
                                         HEAD_GAP, TAIL_GAP);

  int unsigned lv_run;
  int unsigned fv_run;

  always_ff @(posedge clk) begin
    if (srst) begin
      lv_run <= 0;
      fv_run <= 0;
    end else begin
      lv_run <= line_valid  ? lv_run + 1 : 0;
      fv_run <= frame_valid ? fv_run + 1 : 0;
    end
  end

  AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (srst)
    line_valid |-> frame_valid);  // R9

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (srst)
    !line_valid |-> (pix_data == '0));  // R8

  AST_PIXEL_RAMP_STEP: assert property (@(posedge clk) disable iff (srst)
    (line_valid && $past(line_valid)) |-> (pix_data == $past(pix_data) + PIX_W'(1)));  // R7

  AST_HEAD_GAP_QUIET: assert property (@(posedge clk) disable iff (srst)
    $rose(frame_valid) |-> !line_valid);  // R4

  AST_LINE_LENGTH: assert property (@(posedge clk) disable iff (srst)
    ($fell(line_valid) && !$past(srst)) |-> (lv_run == ACTIVE_PIX));  // R2

  AST_FRAME_HIGH_LENGTH: assert property (@(posedge clk) disable iff (srst)
    ($fell(frame_valid) && !$past(srst)) |-> (fv_run == FV_LEN));  // R6

endmodule

bind sensor_frame_timer sensor_frame_timer_chk #(
  .ACTIVE_PIX (ACTIVE_PIX),
  .ACTIVE_ROWS(ACTIVE_ROWS),
  .ROW_GAP    (ROW_GAP),
  .HEAD_GAP   (HEAD_GAP),
  .TAIL_GAP   (TAIL_GAP)
) u_chk (
  .clk        (clk),
  .srst       (srst),
  .frame_valid(frame_valid),
  .line_valid (line_valid),
  .pix_data   (pix_data)
);

// File: tb/sensor_frame_timer_test.sv
module sensor_frame_timer_test;

  localparam int T_PIX  = 1030;  // wide enough for the ramp to wrap past 1023
  localparam int T_ROWS = 3;
  localparam int T_HGAP = 4;
  localparam int T_HEAD = 3;
  localparam int T_TAIL = 2;
  localparam int T_VGAP = 5;
  localparam int T_FV   = T_HEAD + T_ROWS * T_PIX + (T_ROWS - 1) * T_HGAP + T_TAIL;

  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic       enable = 1'b1;
  logic       frame_valid, line_valid;
  logic [9:0] pix_data;

  always #2 clk = ~clk;  // 250 MHz

  sensor_frame_timer #(
    .ACTIVE_PIX (T_PIX),
    .ACTIVE_ROWS(T_ROWS),
    .ROW_GAP    (T_HGAP),
    .HEAD_GAP   (T_HEAD),
    .TAIL_GAP   (T_TAIL),
    .FRAME_GAP  (T_VGAP)
  ) uut (
    .clk        (clk),
    .srst       (srst),
    .enable     (enable),
    .frame_valid(frame_valid),
    .line_valid (line_valid),
    .pix_data   (pix_data)
  );

  typedef struct {
    bit       fv;
    bit       lv;
    bit [9:0] pix;
    string    tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   mon_on   = 0;
  bit   done     = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic push(input bit fv, input bit lv, input int pix, input string tag);
    exp_t e;
    e.fv = fv; e.lv = lv; e.pix = pix[9:0]; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) push(1'b0, 1'b0, 0, tag);
  endtask

  // One frame as the requirements describe it, then the vertical gap.
  task automatic push_frame();
    for (int i = 0; i < T_HEAD; i++) push(1'b1, 1'b0, 0, "R4");
    for (int r = 0; r < T_ROWS; r++) begin
      for (int c = 0; c < T_PIX; c++) push(1'b1, 1'b1, (r + c) % 1024, "R7");
      if (r != T_ROWS - 1)
        for (int i = 0; i < T_HGAP; i++) push(1'b1, 1'b0, 0, "R3");
    end
    for (int i = 0; i < T_TAIL; i++) push(1'b1, 1'b0, 0, "R5");
    push_idle(T_VGAP, "R6");
  endtask

  // Scoreboard monitor: one expected item per sampled cycle.
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(frame_valid == e.fv, e.tag, "frame_valid", frame_valid, e.fv);
      check(line_valid == e.lv, e.tag, "line_valid", line_valid, e.lv);
      check(pix_data == e.pix, e.lv ? "R7" : "R8", "pix_data", pix_data, e.pix);
    end
    if (!srst)
      check(!(line_valid && !frame_valid), "R9", "line_valid outside frame",
            line_valid, 0);
  end

  // Interval monitor: line length, lines per frame, frame period.
  int  lv_run = 0, rows_seen = 0, cyc = 0, rise_n = 0, last_rise = 0;
  bit  lv_prev = 0, fv_prev = 0;
  always @(negedge clk) begin
    cyc++;
    if (srst) begin
      lv_run = 0; rows_seen = 0; rise_n = 0;
    end else begin
      if (line_valid) lv_run++;
      else if (lv_prev) begin
        check(lv_run == T_PIX, "R2", "line length", lv_run, T_PIX);
        rows_seen++;
        lv_run = 0;
      end
      if (fv_prev && !frame_valid) begin
        check(rows_seen == T_ROWS, "R2", "lines per frame", rows_seen, T_ROWS);
        rows_seen = 0;
      end
      if (!fv_prev && frame_valid) begin
        rise_n++;
        if (rise_n == 2)  // both frames run with enable high
          check(cyc - last_rise == T_FV + T_VGAP, "R6", "frame period",
                cyc - last_rise, T_FV + T_VGAP);
        last_rise = cyc;
      end
    end
    lv_prev = line_valid;
    fv_prev = frame_valid;
  end

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1: reset state; this sample is also cycle 0 of the vertical gap
    check(frame_valid == 0, "R1", "frame_valid in reset", frame_valid, 0);
    check(line_valid == 0, "R1", "line_valid in reset", line_valid, 0);
    check(pix_data == 0, "R1", "pix_data in reset", pix_data, 0);
    srst = 1'b0;
    push_idle(T_VGAP - 1, "R1");
    push_frame();
    push_frame();
    push_idle(8, "R10");  // enable dropped in frame 2: outputs stay low
    mon_on = 1;

    wait (q.size() <= 2000);  // inside frame 2
    enable = 1'b0;
    wait (q.size() == 0);
    #1;
    // R10: gap has elapsed, so frame_valid rises one edge after enable
    enable = 1'b1;
    push_frame();

    wait (q.size() <= T_VGAP + 1500);  // middle of frame 3
    mon_on = 0;
    q.delete();
    srst = 1'b1;
    @(negedge clk); #1;
    check(frame_valid == 0, "R1", "frame_valid after mid-frame reset", frame_valid, 0);
    check(line_valid == 0, "R1", "line_valid after mid-frame reset", line_valid, 0);
    check(pix_data == 0, "R1", "pix_data after mid-frame reset", pix_data, 0);
    srst = 1'b0;
    push_idle(T_VGAP - 1, "R1");
    push_frame();
    mon_on = 1;
    wait (q.size() == 0);
    #1;
    finish_test();
  end

endmodule